// File: doc/BRIEF.md
# Redial and Save Memory Dial Sequencer

This block sits between a keypad decoder and the tone or pulse signalling generators of a telephone dialer. It receives decoded key events, a raw hook-switch level and a millisecond tick. From these it issues a stream of dial commands: digits, star, hash, a pulse-to-tone switch, and two lengths of timed pause. It also raises a line-break request during one-key redial. The hook level is filtered before use. While the handset is on-hook the sequencer sleeps and ignores every key.

Two 32-entry stores hold a redial number and a saved number. Every storable entry that is dialed by hand is recorded into the redial store. The store is cleared by the first such entry of each off-hook session, and a number longer than the store disables redial for that number. Each of the two pause keys has two roles. As the first key after going off-hook it replays the redial store. At any later point it inserts and records its pause. A save key opens a silent entry mode that fills the save store, and a recall key replays it. During playback the sequencer issues one entry at a time. After a signal entry it waits for a done handshake from the back-end. After a pause entry it times the pause itself.

Top module: `dial_sequencer`

## Requirements
- R1: The filtered hook state changes only after the raw level has differed from it for DEBOUNCE_MS consecutive ticks (default 150). A shorter excursion leaves it unchanged. `off_hook` is 0 after reset.
- R2: While the filtered state is on-hook, key events produce no command and no line break.
- R3: When the sequencer is ready and off-hook, a key with code 0..12 (digits 0..9, 10 = star, 11 = hash, 12 = pulse-to-tone switch) produces a one-cycle `cmd_valid` with `cmd_code` equal to the key code.
- R4: A pause key (13 = long, 14 = short), pressed as the first key after off-hook, replays the redial store in recorded order, provided the store holds at least one entry and has not overflowed.
- R5: A pause key that is not the first key is issued as command 13 or 14 and recorded. The sequencer then ignores keys for PAUSE_LONG_MS (3600) or PAUSE_SHORT_MS (2000) ticks respectively.
- R6: Pause and pulse-to-tone entries replay from memory. A replayed pause delays the next replayed command by its full tick count.
- R7: In each off-hook session, the first recorded entry empties the redial store. Only entries of that session are replayed afterwards.
- R8: Exactly 32 recorded entries replay completely. A 33rd entry inhibits both redial keys for that number.
- R9: The one-key redial key (code 16) holds `line_break` high for BREAK_MS ticks (default 500) with no command issued, and then replays the redial store.
- R10: The save key (code 15) toggles a save mode. In save mode, entries with codes 0..14 are written to the save store without being issued. The recall key (code 17) replays the save store.
- R11: After issuing a signal command, the sequencer accepts no key and issues no further command until `cmd_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| hook_raw | input | 1 | Raw hook switch, 1 = on-hook |
| key_valid | input | 1 | Key event strobe |
| key_code | input | 5 | Decoded key (0..17) |
| cmd_done | input | 1 | Back-end finished the current signal command |
| cmd_valid | output | 1 | Command strobe, one cycle |
| cmd_code | output | 4 | Command: 0..12 signal, 13/14 pause |
| line_break | output | 1 | Line break request during one-key redial |
| off_hook | output | 1 | Filtered hook state, 1 = off-hook |

## Verification
The hardest state to reach is overflow of the redial store. It only exists after more than 32 hand-dialed entries in one session, each completed through the done handshake, followed by a fresh off-hook session in which the redial key is pressed first. The stimulus therefore dials exactly 32 and then 33 entries in separate sessions and cycles the hook between them. This shows that a full store still replays while an overfull one stays silent for both redial keys. Pause timing is measured as the gap between replayed commands. This is only observable once a pause has been recorded in an earlier session.

// File: rtl/dial_pkg.sv
package dial_pkg;

    typedef enum logic [2:0] {
        S_SLEEP,
        S_READY,
        S_WAIT,
        S_PAUSE,
        S_BREAK,
        S_PLAY
    } seq_st_e;

    localparam logic [4:0] K_PT        = 5'd12;
    localparam logic [4:0] K_PAUSE_L   = 5'd13;
    localparam logic [4:0] K_PAUSE_S   = 5'd14;
    localparam logic [4:0] K_SAVE      = 5'd15;
    localparam logic [4:0] K_ONE_REDIAL = 5'd16;
    localparam logic [4:0] K_RECALL    = 5'd17;

    localparam logic [3:0] E_PAUSE_L = 4'd13;
    localparam logic [3:0] E_PAUSE_S = 4'd14;

endpackage

// File: rtl/dial_hook_filter.sv
module dial_hook_filter #(
    parameter int DEBOUNCE_MS = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic hook_raw,
    output logic off_hook
);
    localparam int CW = $clog2(DEBOUNCE_MS + 1);

    typedef struct packed {
        logic          on_hook;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (hook_raw == r_q.on_hook) begin
            r_d.cnt = '0;
        end else if (tick_ms) begin
            if (r_q.cnt == CW'(DEBOUNCE_MS - 1)) begin
                r_d.on_hook = hook_raw;
                r_d.cnt     = '0;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.on_hook <= 1'b1;
            r_q.cnt     <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign off_hook = !r_q.on_hook;

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt < CW'(DEBOUNCE_MS));

    assert_change_needs_diff_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.on_hook != $past(r_q.on_hook)) |-> ($past(hook_raw) == r_q.on_hook));

endmodule

// File: rtl/dial_store.sv
module dial_store #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wbank,
    input  logic [AW-1:0] waddr,
    input  logic [3:0]    wdata,
    input  logic          rbank,
    input  logic [AW-1:0] raddr,
    output logic [3:0]    rdata
);
    logic [1:0][3:0] bank_rd;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [3:0] cells [DEPTH];
        always_ff @(posedge clk) begin
            if (we && (wbank == 1'(b))) begin
                cells[waddr] <= wdata;
            end
        end
        assign bank_rd[b] = cells[raddr];
    end

    assign rdata = bank_rd[rbank];

endmodule

// File: rtl/dial_seq_ctrl.sv
module dial_seq_ctrl
    import dial_pkg::*;
#(
    parameter int DEPTH          = 32,
    parameter int PAUSE_LONG_MS  = 3600,
    parameter int PAUSE_SHORT_MS = 2000,
    parameter int BREAK_MS       = 500,
    parameter int AW             = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_ms,
    input  logic          off_hook,
    input  logic          key_valid,
    input  logic [4:0]    key_code,
    input  logic          cmd_done,
    input  logic [3:0]    rd_data,
    output logic          rd_bank,
    output logic [AW-1:0] rd_addr,
    output logic          mem_we,
    output logic          mem_bank,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_wdata,
    output logic          cmd_valid,
    output logic [3:0]    cmd_code,
    output logic          line_break
);
    localparam int LW   = $clog2(DEPTH + 1);
    localparam int MAXA = (PAUSE_LONG_MS > PAUSE_SHORT_MS) ? PAUSE_LONG_MS : PAUSE_SHORT_MS;
    localparam int MAXT = (MAXA > BREAK_MS) ? MAXA : BREAK_MS;
    localparam int CW   = $clog2(MAXT + 1);

    typedef struct packed {
        seq_st_e       st;
        logic          first;
        logic          started;
        logic [LW-1:0] rlen;
        logic          ovf;
        logic          saving;
        logic [LW-1:0] slen;
        logic          src;
        logic          playing;
        logic [LW-1:0] idx;
        logic [CW-1:0] cnt;
        logic          cmd_v;
        logic [3:0]    cmd_c;
        logic          brk;
    } ctrl_t;

    ctrl_t r_q, r_d;

    logic          redial_ok;
    logic [LW-1:0] play_len;
    seq_st_e       after;
    logic [CW-1:0] pause_lim;
    logic          key_pause;

    always_comb begin
        r_d       = r_q;
        r_d.cmd_v = 1'b0;
        mem_we    = 1'b0;
        mem_bank  = 1'b0;
        mem_addr  = '0;
        mem_wdata = key_code[3:0];
        rd_bank   = r_q.src;
        rd_addr   = r_q.idx[AW-1:0];
        redial_ok = (r_q.rlen != '0) && !r_q.ovf;
        play_len  = r_q.src ? r_q.slen : r_q.rlen;
        after     = (r_q.playing && (r_q.idx < play_len)) ? S_PLAY : S_READY;
        pause_lim = (r_q.cmd_c == E_PAUSE_S) ? CW'(PAUSE_SHORT_MS - 1) : CW'(PAUSE_LONG_MS - 1);
        key_pause = (key_code == K_PAUSE_L) || (key_code == K_PAUSE_S);

        if (!off_hook) begin
            r_d.st      = S_SLEEP;
            r_d.saving  = 1'b0;
            r_d.brk     = 1'b0;
            r_d.playing = 1'b0;
        end else begin
            unique case (r_q.st)
                S_SLEEP: begin
                    r_d.st      = S_READY;
                    r_d.first   = 1'b1;
                    r_d.started = 1'b0;
                end
                S_READY: begin
                    if (key_valid) begin
                        r_d.first = 1'b0;
                        if (key_code == K_SAVE) begin
                            r_d.saving = !r_q.saving;
                            if (!r_q.saving) r_d.slen = '0;
                        end else if (key_code == K_RECALL) begin
                            if (!r_q.saving && (r_q.slen != '0)) begin
                                r_d.st = S_PLAY; r_d.src = 1'b1;
                                r_d.idx = '0;    r_d.playing = 1'b1;
                            end
                        end else if (key_code == K_ONE_REDIAL) begin
                            if (!r_q.saving && redial_ok) begin
                                r_d.st = S_BREAK; r_d.brk = 1'b1;
                                r_d.cnt = '0;     r_d.src = 1'b0;
                            end
                        end else if (key_code <= K_PAUSE_S) begin
                            if (key_pause && r_q.first && !r_q.saving) begin
                                if (redial_ok) begin
                                    r_d.st = S_PLAY; r_d.src = 1'b0;
                                    r_d.idx = '0;    r_d.playing = 1'b1;
                                end
                            end else if (r_q.saving) begin
                                if (r_q.slen < LW'(DEPTH)) begin
                                    mem_we   = 1'b1;
                                    mem_bank = 1'b1;
                                    mem_addr = r_q.slen[AW-1:0];
                                    r_d.slen = r_q.slen + 1'b1;
                                end
                            end else begin
                                if (!r_q.started) begin
                                    mem_we = 1'b1; mem_addr = '0;
                                    r_d.rlen = LW'(1); r_d.ovf = 1'b0;
                                    r_d.started = 1'b1;
                                end else if (r_q.rlen < LW'(DEPTH)) begin
                                    mem_we = 1'b1; mem_addr = r_q.rlen[AW-1:0];
                                    r_d.rlen = r_q.rlen + 1'b1;
                                end else begin
                                    r_d.ovf = 1'b1;
                                end
                                r_d.cmd_v   = 1'b1;
                                r_d.cmd_c   = key_code[3:0];
                                r_d.cnt     = '0;
                                r_d.playing = 1'b0;
                                r_d.st      = key_pause ? S_PAUSE : S_WAIT;
                            end
                        end
                    end
                end
                S_BREAK: begin
                    if (tick_ms) begin
                        if (r_q.cnt == CW'(BREAK_MS - 1)) begin
                            r_d.brk = 1'b0; r_d.st = S_PLAY;
                            r_d.idx = '0;   r_d.playing = 1'b1;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                S_PLAY: begin
                    r_d.cmd_v = 1'b1;
                    r_d.cmd_c = rd_data;
                    r_d.idx   = r_q.idx + 1'b1;
                    r_d.cnt   = '0;
                    r_d.st    = ((rd_data == E_PAUSE_L) || (rd_data == E_PAUSE_S)) ? S_PAUSE : S_WAIT;
                end
                S_WAIT: begin
                    if (cmd_done) begin
                        r_d.st = after;
                        if (after == S_READY) r_d.playing = 1'b0;
                    end
                end
                S_PAUSE: begin
                    if (tick_ms) begin
                        if (r_q.cnt == pause_lim) begin
                            r_d.st = after;
                            if (after == S_READY) r_d.playing = 1'b0;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
                default: r_d.st = S_SLEEP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= S_SLEEP;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_valid  = r_q.cmd_v;
    assign cmd_code   = r_q.cmd_c;
    assign line_break = r_q.brk;

    assert_len_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.rlen <= LW'(DEPTH)) && (r_q.slen <= LW'(DEPTH)));

    assert_break_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.brk |-> !r_q.cmd_v);

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cmd_v |=> !r_q.cmd_v);

    assert_play_idx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_PLAY) |-> (r_q.idx < play_len));

    assert_wait_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_WAIT && off_hook && !cmd_done) |=> (r_q.st == S_WAIT && !r_q.cmd_v));

endmodule

// File: rtl/dial_sequencer.sv
module dial_sequencer
    import dial_pkg::*;
#(
    parameter int DEPTH          = 32,
    parameter int DEBOUNCE_MS    = 150,
    parameter int PAUSE_LONG_MS  = 3600,
    parameter int PAUSE_SHORT_MS = 2000,
    parameter int BREAK_MS       = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       hook_raw,
    input  logic       key_valid,
    input  logic [4:0] key_code,
    input  logic       cmd_done,
    output logic       cmd_valid,
    output logic [3:0] cmd_code,
    output logic       line_break,
    output logic       off_hook
);
    localparam int AW = $clog2(DEPTH);

    logic          rd_bank, mem_we, mem_bank;
    logic [AW-1:0] rd_addr, mem_addr;
    logic [3:0]    rd_data, mem_wdata;

    dial_hook_filter #(.DEBOUNCE_MS(DEBOUNCE_MS)) u_filter (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
        .hook_raw(hook_raw), .off_hook(off_hook)
    );

    dial_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .we(mem_we), .wbank(mem_bank), .waddr(mem_addr),
        .wdata(mem_wdata), .rbank(rd_bank), .raddr(rd_addr), .rdata(rd_data)
    );

    dial_seq_ctrl #(
        .DEPTH(DEPTH), .PAUSE_LONG_MS(PAUSE_LONG_MS),
        .PAUSE_SHORT_MS(PAUSE_SHORT_MS), .BREAK_MS(BREAK_MS), .AW(AW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .off_hook(off_hook),
        .key_valid(key_valid), .key_code(key_code), .cmd_done(cmd_done),
        .rd_data(rd_data), .rd_bank(rd_bank), .rd_addr(rd_addr),
        .mem_we(mem_we), .mem_bank(mem_bank), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .line_break(line_break)
    );

    assert_sleep_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !off_hook |=> (!cmd_valid && !line_break));

endmodule

// File: tb/test_dial_sequencer.sv
module test_dial_sequencer;
    import dial_pkg::*;

    localparam int BRK = 500;

    logic       clk = 1'b0;
    logic       rst_n, tick_ms, hook_raw, key_valid, cmd_done;
    logic [4:0] key_code;
    logic       cmd_valid, line_break, off_hook;
    logic [3:0] cmd_code;

    always #5 clk = ~clk;

    dial_sequencer i_dial_sequencer (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .hook_raw(hook_raw),
        .key_valid(key_valid), .key_code(key_code), .cmd_done(cmd_done),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .line_break(line_break), .off_hook(off_hook)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [3:0] cap   [0:511];
    int         cap_t [0:511];
    int         cap_n = 0;
    int         pend = 0;
    bit         hold_done = 1'b0;
    bit         force_done = 1'b0;

    // back-end model: capture commands, answer signal commands after a delay
    always @(negedge clk) begin
        cyc = cyc + 1;
        cmd_done = force_done || (pend == 1);
        if (pend > 0) pend = pend - 1;
        if (cmd_valid) begin
            if (cap_n < 512) begin
                cap[cap_n] = cmd_code;
                cap_t[cap_n] = cyc;
            end
            cap_n = cap_n + 1;
            if (cmd_code < 4'd13 && !hold_done) pend = 3;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic press(input logic [4:0] k);
        @(negedge clk);
        key_valid = 1'b1;
        key_code  = k;
        @(negedge clk);
        key_valid = 1'b0;
    endtask

    task automatic go_on();
        hook_raw = 1'b1;
        waitc(170);
    endtask

    task automatic go_off();
        hook_raw = 1'b0;
        waitc(170);
    endtask

    localparam int NV = 8;
    localparam logic [4:0] VK [NV] = '{5'd3, 5'd1, 5'd4, 5'd1, 5'd10, 5'd11, 5'd12, 5'd0};
    localparam logic [3:0] VE [NV] = '{4'd3, 4'd1, 4'd4, 4'd1, 4'd10, 4'd11, 4'd12, 4'd0};
    localparam int NR = 12;
    localparam logic [3:0] RED [NR] = '{4'd3, 4'd1, 4'd4, 4'd1, 4'd10, 4'd11, 4'd12, 4'd0,
                                        4'd7, 4'd9, 4'd14, 4'd2};

    initial begin
        waitc(150000);
        if (!finished) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int b;
        int g;
        rst_n = 1'b0; tick_ms = 1'b1; hook_raw = 1'b1;
        key_valid = 1'b0; key_code = '0;
        waitc(5);
        rst_n = 1'b1;
        waitc(2);

        // R1 reset state
        chk(off_hook == 1'b0, "R1 reset off_hook", int'(off_hook), 0);
        chk(cmd_valid == 1'b0 && line_break == 1'b0, "R1 reset outputs",
            int'(cmd_valid) + int'(line_break), 0);

        // R2 keys ignored while on-hook
        press(5'd5); waitc(10);
        chk(cap_n == 0, "R2 on-hook key", cap_n, 0);

        // R1 short excursion filtered
        hook_raw = 1'b0; waitc(100);
        chk(off_hook == 1'b0, "R1 short off-hook glitch", int'(off_hook), 0);
        hook_raw = 1'b1; waitc(20);
        hook_raw = 1'b0; waitc(100);
        chk(off_hook == 1'b0, "R1 counter restarts", int'(off_hook), 0);
        waitc(70);
        chk(off_hook == 1'b1, "R1 off-hook accepted", int'(off_hook), 1);
        hook_raw = 1'b1; waitc(100); hook_raw = 1'b0; waitc(5);
        chk(off_hook == 1'b1, "R1 short on-hook glitch", int'(off_hook), 1);

        // R3 table of keys and expected commands
        for (int i = 0; i < NV; i++) begin
            b = cap_n;
            press(VK[i]); waitc(8);
            chk(cap_n == b + 1 && cap[b] == VE[i], "R3 manual dial",
                int'(cap[b]), int'(VE[i]));
        end

        // R11 no progress without done
        hold_done = 1'b1;
        b = cap_n;
        press(5'd7); waitc(5);
        press(5'd8); waitc(20);
        chk(cap_n == b + 1 && cap[b] == 4'd7, "R11 key blocked until done", cap_n - b, 1);
        @(negedge clk); force_done = 1'b1;
        @(negedge clk); force_done = 1'b0;
        hold_done = 1'b0;
        press(5'd9); waitc(10);
        chk(cap_n == b + 2 && cap[b + 1] == 4'd9, "R11 resumes after done",
            int'(cap[b + 1]), 9);

        // R5 short pause as a later key
        b = cap_n;
        press(K_PAUSE_S); waitc(5);
        chk(cap_n == b + 1 && cap[b] == E_PAUSE_S, "R5 pause command", int'(cap[b]), 14);
        waitc(100);
        press(5'd6); waitc(10);
        chk(cap_n == b + 1, "R5 key ignored during pause", cap_n - b, 1);
        waitc(2050);
        press(5'd2); waitc(10);
        chk(cap_n == b + 2 && cap[b + 1] == 4'd2, "R5 key after pause", int'(cap[b + 1]), 2);

        // R4 redial as first key, R6 replayed pause timing
        go_on(); go_off();
        b = cap_n;
        press(K_PAUSE_L); waitc(2400);
        chk(cap_n == b + NR, "R4 replay length", cap_n - b, NR);
        for (int i = 0; i < NR; i++)
            chk(cap[b + i] == RED[i], "R4 replay order", int'(cap[b + i]), int'(RED[i]));
        g = cap_t[b + 11] - cap_t[b + 10];
        chk(g >= 2000 && g <= 2006, "R6 short pause replay gap", g, 2002);

        // R7 new session clears at first entry, long pause recorded
        press(5'd5); waitc(10);
        press(K_PAUSE_L); waitc(3700);
        press(5'd8); waitc(10);
        go_on(); go_off();
        b = cap_n;
        press(K_PAUSE_S); waitc(3800);
        chk(cap_n == b + 3, "R7 only new session replayed", cap_n - b, 3);
        chk(cap[b] == 4'd5 && cap[b + 1] == E_PAUSE_L && cap[b + 2] == 4'd8,
            "R7 replay content", int'(cap[b + 1]), 13);
        g = cap_t[b + 2] - cap_t[b + 1];
        chk(g >= 3600 && g <= 3606, "R6 long pause replay gap", g, 3602);

        // R9 one-key redial
        b = cap_n;
        press(K_ONE_REDIAL); waitc(5);
        chk(line_break == 1'b1, "R9 break asserted", int'(line_break), 1);
        chk(cap_n == b, "R9 silent during break", cap_n - b, 0);
        waitc(BRK + 10);
        chk(line_break == 1'b0, "R9 break released", int'(line_break), 0);
        chk(cap_n > b && cap[b] == 4'd5, "R9 replay after break", int'(cap[b]), 5);
        waitc(3800);
        chk(cap_n == b + 3, "R9 full replay", cap_n - b, 3);

        // R10 save and recall
        b = cap_n;
        press(K_SAVE); waitc(4);
        press(5'd4);   waitc(4);
        press(5'd2);   waitc(4);
        press(K_SAVE); waitc(4);
        chk(cap_n == b, "R10 save is silent", cap_n - b, 0);
        press(K_RECALL); waitc(30);
        chk(cap_n == b + 2 && cap[b] == 4'd4 && cap[b + 1] == 4'd2, "R10 recall",
            cap_n - b, 2);

        // R8 exactly full store replays
        go_on(); go_off();
        for (int i = 0; i < 32; i++) begin
            press(5'(i % 10)); waitc(8);
        end
        go_on(); go_off();
        b = cap_n;
        press(K_PAUSE_L); waitc(32 * 8 + 50);
        chk(cap_n == b + 32, "R8 32 entries replay", cap_n - b, 32);
        chk(cap[b + 31] == 4'd1, "R8 last entry", int'(cap[b + 31]), 1);

        // R8 overflow inhibits redial
        go_on(); go_off();
        for (int i = 0; i < 33; i++) begin
            press(5'(i % 10)); waitc(8);
        end
        go_on(); go_off();
        b = cap_n;
        press(K_PAUSE_L); waitc(50);
        chk(cap_n == b, "R8 overflow inhibits redial key", cap_n - b, 0);
        press(K_ONE_REDIAL); waitc(5);
        chk(line_break == 1'b0 && cap_n == b, "R8 overflow inhibits one-key redial",
            int'(line_break), 0);

        // R2 on-hook aborts and silences
        go_on();
        b = cap_n;
        press(K_RECALL); waitc(20);
        chk(cap_n == b && line_break == 1'b0, "R2 recall ignored on-hook", cap_n - b, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule